// File: doc/BRIEF.md
# Interrupt Controller Base Register with Mode Guard

This block is the architectural base register of a processor's local interrupt controller. It keeps a bootstrap-processor flag, two mode bits (global enable and extended enable) and the physical page of the controller's register window. Software writes it through a single write port. Each write is checked against the reserved-bit mask, the physical address width and the legal mode transitions. A rejected write raises a fault and leaves the register as it was. An accepted write updates the stored value and the base output, and raises a relocation strobe and a translation-flush pulse for one cycle.

The two mode bits form a state machine with four encodings. `MODE_OFF` (00) is fully disabled and can be left only by reset. `MODE_ENABLED` (10) is the classic memory-mapped mode. `MODE_EXTENDED` (11) is the extended register-access mode. `MODE_ILLEGAL` (01) can never be entered. The named transitions are:
- ENABLE_TO_EXTENDED (10 to 11)
- ENABLE_TO_OFF (10 to 00)
- EXTENDED_TO_OFF (11 to 00)
- STAY (same state, with a new base or flag)

Every other change is a fault: ANY_TO_ILLEGAL and EXTENDED_TO_ENABLED are both rejected. A gate output tells the extended register decoder whether its range is open. A request into that range while the gate is closed is flagged at once.

Top module: `lic_base_reg`

## Requirements
- R1: After reset the read value is 0xFEE00800 with bit 8 equal to the strap input. The mode is `MODE_ENABLED`, `base_o` is 0xFEE00000, and all strobes and the fault are low.
- R2: An accepted write stores the written value and drives the new base on `base_o`. In the cycle after the write, `relocate_o` and `flush_o` are high for exactly one cycle and `wr_fault_o` is low.
- R3: A write with any of bits 7:0 or bit 9 set raises `wr_fault_o` for one cycle in the cycle after the write and leaves the read value unchanged.
- R4: When the parameter `EXT_EN` is 0, bit 10 is also reserved, so a write setting it faults.
- R5: A write with any bit at or above `PHYS_W` (default 36) set faults. Bit `PHYS_W`-1 is a legal base bit.
- R6: A write whose mode bits 11:10 would move the state to 01 (extended set, global clear) faults.
- R7: From `MODE_EXTENDED`, a write to mode 10 faults. A write to mode 00 is accepted.
- R8: While the stored global-enable bit 11 is clear, writes give no fault, no strobe and no change to the read value.
- R9: `ext_gate_o` equals stored bit 10. `ext_fault_o` is high exactly when `ext_req_i` is high while the gate is closed, in the same cycle.
- R10: From `MODE_EXTENDED`, a write keeping mode 11 with a new base is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsp_strap_i | input | 1 | Bootstrap-processor flag loaded at reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 64 | Write value |
| wr_fault_o | output | 1 | Write rejected (one cycle, after the write) |
| rd_data_o | output | 64 | Current register value |
| base_o | output | 36 | Controller physical base address |
| relocate_o | output | 1 | New base valid strobe |
| flush_o | output | 1 | Translation-flush pulse |
| ext_gate_o | output | 1 | Extended register range accessible |
| ext_req_i | input | 1 | Access attempt into the extended range |
| ext_fault_o | output | 1 | Extended access denied |

## Verification
Writes are applied in a fixed order that walks the mode machine through ENABLE_TO_EXTENDED, STAY, a rejected EXTENDED_TO_ENABLED and EXTENDED_TO_OFF. This separates a correct transition table from one that allows any change or forbids them all. Single reserved bits (bit 0, bit 9, and bit 10 on a second instance built without extended support) and an address one bit too wide are each paired with the largest legal neighbour. This shows that the masks sit on the right bit boundary. Writes after disabling show that the frozen state also suppresses the strobes, not only the stored value.

// File: rtl/lic_pkg.sv
package lic_pkg;

    // Mode encoding is {global_enable, extended_enable} at bits 11:10.
    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_ILLEGAL  = 2'b01,
        MODE_ENABLED  = 2'b10,
        MODE_EXTENDED = 2'b11
    } lic_mode_e;

    localparam int unsigned BSP_BIT  = 8;
    localparam int unsigned EXT_BIT  = 10;
    localparam int unsigned GLB_BIT  = 11;
    localparam int unsigned PAGE_LSB = 12;

endpackage

// File: rtl/lic_wr_check.sv
module lic_wr_check
    import lic_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned PHYS_W = 36,
    parameter bit          EXT_EN = 1'b1
) (
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              rsvd_err_o,
    output logic              addr_err_o,
    output lic_mode_e         req_mode_o
);

    localparam logic [DATA_W-1:0] BASE_RSVD = DATA_W'(32'h0000_02FF);
    localparam logic [DATA_W-1:0] EXT_RSVD  = EXT_EN ? '0 : DATA_W'(32'h0000_0400);
    localparam logic [DATA_W-1:0] LOW_RSVD  = BASE_RSVD | EXT_RSVD;
    localparam logic [DATA_W-1:0] ADDR_OK   = (DATA_W'(1) << PHYS_W) - DATA_W'(1);

    always_comb begin
        rsvd_err_o = |(wr_data_i & LOW_RSVD);
        addr_err_o = |(wr_data_i & ~ADDR_OK);
        req_mode_o = lic_mode_e'(wr_data_i[GLB_BIT:EXT_BIT]);
    end

endmodule

// File: rtl/lic_mode_fsm.sv
module lic_mode_fsm
    import lic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lic_mode_e req_mode_i,
    input  logic      commit_i,
    output lic_mode_e mode_o,
    output logic      trans_ok_o,
    output logic      enabled_o,
    output logic      ext_gate_o
);

    lic_mode_e mode_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_ENABLED;
        end else if (commit_i) begin
            mode_q <= req_mode_i;
        end
    end

    // Transition legality and outputs
    always_comb begin
        trans_ok_o = 1'b0;
        unique case (mode_q)
            MODE_OFF:      trans_ok_o = 1'b0;
            MODE_ILLEGAL:  trans_ok_o = 1'b0;
            MODE_ENABLED:  trans_ok_o = (req_mode_i != MODE_ILLEGAL);
            MODE_EXTENDED: trans_ok_o = (req_mode_i == MODE_EXTENDED) ||
                                        (req_mode_i == MODE_OFF);
        endcase
        mode_o     = mode_q;
        enabled_o  = mode_q[1];
        ext_gate_o = mode_q[0];
    end

    a_r6_never_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_ILLEGAL);

    a_r7_ext_exit_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_EXTENDED && mode_q != MODE_EXTENDED) |-> mode_q == MODE_OFF);

    a_r8_off_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_OFF |=> mode_q == MODE_OFF);

endmodule

// File: rtl/lic_base_reg.sv
module lic_base_reg
    import lic_pkg::*;
#(
    parameter int unsigned       DATA_W     = 64,
    parameter int unsigned       PHYS_W     = 36,
    parameter bit                EXT_EN     = 1'b1,
    parameter logic [PHYS_W-1:0] RESET_BASE = PHYS_W'(32'hFEE0_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bsp_strap_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wr_fault_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [PHYS_W-1:0] base_o,
    output logic              relocate_o,
    output logic              flush_o,
    output logic              ext_gate_o,
    input  logic              ext_req_i,
    output logic              ext_fault_o
);

    localparam int unsigned PAGE_W = PHYS_W - PAGE_LSB;

    logic      rsvd_err, addr_err, trans_ok, enabled, gate;
    lic_mode_e req_mode, mode;
    logic      accept, reject;

    logic [PAGE_W-1:0] page_q;
    logic              bsp_q;
    logic              fault_q, reloc_q, flush_q;

    lic_wr_check #(
        .DATA_W (DATA_W),
        .PHYS_W (PHYS_W),
        .EXT_EN (EXT_EN)
    ) u_check (
        .wr_data_i  (wr_data_i),
        .rsvd_err_o (rsvd_err),
        .addr_err_o (addr_err),
        .req_mode_o (req_mode)
    );

    lic_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_mode_i (req_mode),
        .commit_i   (accept),
        .mode_o     (mode),
        .trans_ok_o (trans_ok),
        .enabled_o  (enabled),
        .ext_gate_o (gate)
    );

    // Writes while globally disabled are silently dropped.
    always_comb begin
        reject = wr_en_i && enabled && (rsvd_err || addr_err || !trans_ok);
        accept = wr_en_i && enabled && !(rsvd_err || addr_err || !trans_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= RESET_BASE[PHYS_W-1:PAGE_LSB];
            bsp_q   <= bsp_strap_i;
            fault_q <= 1'b0;
            reloc_q <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            fault_q <= reject;
            reloc_q <= accept;
            flush_q <= accept;
            if (accept) begin
                page_q <= wr_data_i[PHYS_W-1:PAGE_LSB];
                bsp_q  <= wr_data_i[BSP_BIT];
            end
        end
    end

    always_comb begin
        rd_data_o                          = '0;
        rd_data_o[PHYS_W-1:PAGE_LSB]       = page_q;
        rd_data_o[GLB_BIT:EXT_BIT]         = mode;
        rd_data_o[BSP_BIT]                 = bsp_q;
        base_o                             = {page_q, {PAGE_LSB{1'b0}}};
        wr_fault_o                         = fault_q;
        relocate_o                         = reloc_q;
        flush_o                            = flush_q;
        ext_gate_o                         = gate;
        ext_fault_o                        = ext_req_i && !gate;
    end

    a_r2_no_strobe_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
        relocate_o |-> !wr_fault_o);

    a_r2_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relocate_o) |-> $past(wr_en_i));

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> $stable(rd_data_o));

    a_r9_ext_fault_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fault_o |-> !ext_gate_o);

    a_r8_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[GLB_BIT] |=> !relocate_o && !wr_fault_o);

endmodule

// File: tb/lic_base_reg_tb_top.sv
module lic_base_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_en_b = 1'b0, ext_req = 1'b0;
    logic [63:0] wr_data = '0, wr_data_b = '0;

    logic        fault, reloc, flush, gate, ext_fault;
    logic [63:0] rd;
    logic [35:0] base;
    logic        fault_b, reloc_b, flush_b, gate_b, ext_fault_b;
    logic [63:0] rd_b;
    logic [35:0] base_b;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lic_base_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bsp_strap_i(1'b1),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_fault_o(fault),
        .rd_data_o(rd), .base_o(base), .relocate_o(reloc), .flush_o(flush),
        .ext_gate_o(gate), .ext_req_i(ext_req), .ext_fault_o(ext_fault)
    );

    lic_base_reg #(.EXT_EN(1'b0)) dut_noext (
        .clk(clk), .rst_n(rst_n), .bsp_strap_i(1'b0),
        .wr_en_i(wr_en_b), .wr_data_i(wr_data_b), .wr_fault_o(fault_b),
        .rd_data_o(rd_b), .base_o(base_b), .relocate_o(reloc_b), .flush_o(flush_b),
        .ext_gate_o(gate_b), .ext_req_i(1'b0), .ext_fault_o(ext_fault_b)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Write on dut_i, then check outcome in the following cycle and the strobe drop.
    task automatic wr_main(input string req, input logic [63:0] v,
                           input logic exp_fault, input logic exp_strobe,
                           input logic [63:0] exp_rd);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
        check(req, "fault",    64'(fault), 64'(exp_fault));
        check(req, "relocate", 64'(reloc), 64'(exp_strobe));
        check(req, "flush",    64'(flush), 64'(exp_strobe));
        check(req, "rd_data",  rd, exp_rd);
        @(negedge clk);
        check(req, "strobe one cycle", 64'(reloc | flush | fault), 64'd0);
    endtask

    task automatic t_reset();
        check("R1", "rd_data", rd, 64'hFEE0_0900);
        check("R1", "base", 64'(base), 64'hFEE0_0000);
        check("R1", "strobes", 64'({fault, reloc, flush, gate}), 64'd0);
        check("R1", "noext rd_data", rd_b, 64'hFEE0_0800);
    endtask

    task automatic t_gate_closed();
        @(negedge clk); ext_req = 1'b1; #1;
        check("R9", "ext_fault closed", 64'(ext_fault), 64'd1);
        ext_req = 1'b0; #1;
        check("R9", "ext_fault idle", 64'(ext_fault), 64'd0);
    endtask

    task automatic t_accept();
        wr_main("R2", 64'h0000_0000_FEC0_0800, 1'b0, 1'b1, 64'h0000_0000_FEC0_0800);
        check("R2", "base", 64'(base), 64'hFEC0_0000);
    endtask

    task automatic t_reserved();
        wr_main("R3", 64'h0000_0000_FEE0_0801, 1'b1, 1'b0, 64'h0000_0000_FEC0_0800);
        wr_main("R3", 64'h0000_0000_FEE0_0A00, 1'b1, 1'b0, 64'h0000_0000_FEC0_0800);
    endtask

    task automatic t_addr();
        wr_main("R5", 64'h0000_0010_0000_0800, 1'b1, 1'b0, 64'h0000_0000_FEC0_0800);
        wr_main("R5", 64'h0000_0008_0000_0800, 1'b0, 1'b1, 64'h0000_0008_0000_0800);
        check("R5", "base top bit", 64'(base), 64'h0000_0008_0000_0000);
    endtask

    task automatic t_illegal();
        wr_main("R6", 64'h0000_0000_FEE0_0400, 1'b1, 1'b0, 64'h0000_0008_0000_0800);
    endtask

    task automatic t_extended();
        wr_main("R7", 64'h0000_0000_FEE0_0C00, 1'b0, 1'b1, 64'h0000_0000_FEE0_0C00);
        check("R9", "gate open", 64'(gate), 64'd1);
        @(negedge clk); ext_req = 1'b1; #1;
        check("R9", "ext_fault open", 64'(ext_fault), 64'd0);
        ext_req = 1'b0;
        wr_main("R7", 64'h0000_0000_FEE0_0800, 1'b1, 1'b0, 64'h0000_0000_FEE0_0C00);
        wr_main("R10", 64'h0000_0000_FED0_0D00, 1'b0, 1'b1, 64'h0000_0000_FED0_0D00);
        check("R10", "base", 64'(base), 64'hFED0_0000);
        wr_main("R7", 64'h0000_0000_FED0_0000, 1'b0, 1'b1, 64'h0000_0000_FED0_0000);
        check("R9", "gate closed after off", 64'(gate), 64'd0);
    endtask

    task automatic t_disabled();
        wr_main("R8", 64'h0000_0000_FEE0_0800, 1'b0, 1'b0, 64'h0000_0000_FED0_0000);
        wr_main("R8", 64'h0000_0000_FEE0_0801, 1'b0, 1'b0, 64'h0000_0000_FED0_0000);
    endtask

    task automatic t_noext();
        @(negedge clk); wr_en_b = 1'b1; wr_data_b = 64'h0000_0000_FEE0_0C00;
        @(negedge clk); wr_en_b = 1'b0;
        check("R4", "fault", 64'(fault_b), 64'd1);
        check("R4", "rd_data", rd_b, 64'hFEE0_0800);
        @(negedge clk); wr_en_b = 1'b1; wr_data_b = 64'h0000_0000_FEC0_0900;
        @(negedge clk); wr_en_b = 1'b0;
        check("R4", "legal fault", 64'(fault_b), 64'd0);
        check("R4", "legal relocate", 64'(reloc_b & flush_b), 64'd1);
        check("R4", "legal rd", rd_b, 64'hFEC0_0900);
        check("R4", "legal base", 64'(base_b), 64'hFEC0_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate_closed();
        t_accept();
        t_reserved();
        t_addr();
        t_illegal();
        t_extended();
        t_disabled();
        t_noext();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule